// File: doc/BRIEF.md
# SHA-256 Word-Serial Hash Engine

This block computes the SHA-256 digest of a message that arrives one 32-bit word per accepted load, most significant word of each 512-bit block first. The engine pads the message itself. The source flags the final word and states how many of its leading bits carry data. The engine then appends the terminating one bit, the zero fill and the 64-bit bit count, and adds an extra block when the count does not fit. The compression runs one round per clock. Each block costs one cycle to load the working variables and then 64 cycles of rounds.

The chaining state starts from the standard SHA-256 initial hash values. Before the first word of a message, the source may replace it with eight words of its own, for example precomputed inner or outer keyed states. When the last block is finished, the eight digest words appear on consecutive cycles with a strobe and a word address. The chaining state then returns to the standard values.

Top module: `sha256_engine`

## Requirements
- R1: After reset, ready_o is high and strb_o is low.
- R2: With no loaded initial value, the digest equals the standard SHA-256 digest of the message. Words are big-endian: bit 31 of the first word is the first message bit.
- R3: A word is taken only on a rising clock edge where load_i and ready_o are both high. Loads presented while ready_o is low do not change the digest.
- R4: On a word with last_i high, nbits_i gives the number of valid leading bits (1 to 31), and the value 0 means all 32 bits. Bits below the valid ones do not affect the digest, and the word is followed by the standard padding.
- R5: When the one bit and the 64-bit count do not fit in the block holding the last data bit, the engine processes one further block made of zeros and the count.
- R6: After the sixteenth word of a block that is not the last is accepted, ready_o stays low for exactly 65 cycles: one load cycle and 64 round cycles.
- R7: The digest comes out as eight words on consecutive cycles with strb_o high. addr_o counts 0 to 7, and address 0 is the most significant word. strb_o is low at all other times.
- R8: Words loaded with ivsel_i high, before the first message word, replace the chaining values in order, starting with the most significant word. The next message is then hashed from them.
- R9: A load with ivsel_i high is ignored once a message has begun.
- R10: After a digest has been read out, the chaining state returns to the standard initial values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| load_i | input | 1 | Load strobe for data_i |
| ivsel_i | input | 1 | With load_i: the word is an initial chaining value |
| data_i | input | 32 | Message or initial-value word |
| last_i | input | 1 | Marks the final message word |
| nbits_i | input | 5 | Valid leading bits of the final word, 0 meaning 32 |
| q_o | output | 32 | Digest word |
| ready_o | output | 1 | High when a word can be accepted |
| strb_o | output | 1 | Digest word valid on q_o |
| addr_o | output | 3 | Index of the digest word on q_o |

## Verification
The hardest situation to reach is the spill of the padding into an extra block. This happens only when the last data bit lands in word 14 or 15 of a block, or when a full final word fills word 13 or later. A 14-word message ending on a full word forces the one bit into word 14 and the count into a block of its own. A 17-word message drives the engine through a full block, the 65-cycle busy window, and then a short final block. Loads held high through that busy window, with garbage data, show that a stalled source cannot corrupt the block.

// File: rtl/sha256_pkg.sv
package sha256_pkg;

   localparam int WORD_W   = 32;
   localparam int BLK_WRDS = 16;
   localparam int N_ROUNDS = 64;
   localparam int N_CHAIN  = 8;

   typedef logic [0:N_CHAIN-1][WORD_W-1:0] chain_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_PAD, ST_LOAD, ST_RUN, ST_OUT
   } eng_state_t;

   localparam chain_t H_START = {
      32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
      32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

   function automatic logic [31:0] ror(input logic [31:0] x, input int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   function automatic logic [31:0] sig_lo0(input logic [31:0] x);
      return ror(x, 7) ^ ror(x, 18) ^ (x >> 3);
   endfunction

   function automatic logic [31:0] sig_lo1(input logic [31:0] x);
      return ror(x, 17) ^ ror(x, 19) ^ (x >> 10);
   endfunction

   function automatic logic [31:0] sig_up0(input logic [31:0] x);
      return ror(x, 2) ^ ror(x, 13) ^ ror(x, 22);
   endfunction

   function automatic logic [31:0] sig_up1(input logic [31:0] x);
      return ror(x, 6) ^ ror(x, 11) ^ ror(x, 25);
   endfunction

   function automatic logic [31:0] round_const(input logic [5:0] i);
      case (i)
         6'd0:  return 32'h428a2f98;  6'd1:  return 32'h71374491;
         6'd2:  return 32'hb5c0fbcf;  6'd3:  return 32'he9b5dba5;
         6'd4:  return 32'h3956c25b;  6'd5:  return 32'h59f111f1;
         6'd6:  return 32'h923f82a4;  6'd7:  return 32'hab1c5ed5;
         6'd8:  return 32'hd807aa98;  6'd9:  return 32'h12835b01;
         6'd10: return 32'h243185be;  6'd11: return 32'h550c7dc3;
         6'd12: return 32'h72be5d74;  6'd13: return 32'h80deb1fe;
         6'd14: return 32'h9bdc06a7;  6'd15: return 32'hc19bf174;
         6'd16: return 32'he49b69c1;  6'd17: return 32'hefbe4786;
         6'd18: return 32'h0fc19dc6;  6'd19: return 32'h240ca1cc;
         6'd20: return 32'h2de92c6f;  6'd21: return 32'h4a7484aa;
         6'd22: return 32'h5cb0a9dc;  6'd23: return 32'h76f988da;
         6'd24: return 32'h983e5152;  6'd25: return 32'ha831c66d;
         6'd26: return 32'hb00327c8;  6'd27: return 32'hbf597fc7;
         6'd28: return 32'hc6e00bf3;  6'd29: return 32'hd5a79147;
         6'd30: return 32'h06ca6351;  6'd31: return 32'h14292967;
         6'd32: return 32'h27b70a85;  6'd33: return 32'h2e1b2138;
         6'd34: return 32'h4d2c6dfc;  6'd35: return 32'h53380d13;
         6'd36: return 32'h650a7354;  6'd37: return 32'h766a0abb;
         6'd38: return 32'h81c2c92e;  6'd39: return 32'h92722c85;
         6'd40: return 32'ha2bfe8a1;  6'd41: return 32'ha81a664b;
         6'd42: return 32'hc24b8b70;  6'd43: return 32'hc76c51a3;
         6'd44: return 32'hd192e819;  6'd45: return 32'hd6990624;
         6'd46: return 32'hf40e3585;  6'd47: return 32'h106aa070;
         6'd48: return 32'h19a4c116;  6'd49: return 32'h1e376c08;
         6'd50: return 32'h2748774c;  6'd51: return 32'h34b0bcb5;
         6'd52: return 32'h391c0cb3;  6'd53: return 32'h4ed8aa4a;
         6'd54: return 32'h5b9cca4f;  6'd55: return 32'h682e6ff3;
         6'd56: return 32'h748f82ee;  6'd57: return 32'h78a5636f;
         6'd58: return 32'h84c87814;  6'd59: return 32'h8cc70208;
         6'd60: return 32'h90befffa;  6'd61: return 32'ha4506ceb;
         6'd62: return 32'hbef9a3f7;  default: return 32'hc67178f2;
      endcase
   endfunction

endpackage

// File: rtl/sha256_sched.sv
// Sixteen-word block buffer that doubles as the sliding message-schedule window.
module sha256_sched
   import sha256_pkg::*;
#(
   parameter int DEPTH = BLK_WRDS
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_idx,
   input  logic [WORD_W-1:0]        wr_data,
   input  logic                     shift_en,
   output logic [WORD_W-1:0]        w_cur
);

   generate
      if (DEPTH != 16) begin : g_bad_depth
         $error("sha256_sched: DEPTH must be 16");
      end
   endgenerate

   logic [WORD_W-1:0] win [DEPTH];
   logic [WORD_W-1:0] w_new;

   assign w_cur = win[0];
   assign w_new = sig_lo1(win[14]) + win[9] + sig_lo0(win[1]) + win[0];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) win[i] <= '0;
      end else if (shift_en) begin
         for (int i = 0; i < DEPTH - 1; i++) win[i] <= win[i+1];
         win[DEPTH-1] <= w_new;
      end else if (wr_en) begin
         win[wr_idx] <= wr_data;
      end
   end

endmodule

// File: rtl/sha256_round.sv
// Working variables a..h and the single-round compression step.
module sha256_round
   import sha256_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              init,
   input  logic              step,
   input  chain_t            h_in,
   input  logic [WORD_W-1:0] k_t,
   input  logic [WORD_W-1:0] w_t,
   output chain_t            nxt
);

   chain_t            v;
   logic [WORD_W-1:0] t1, t2, ch, mj;

   always_comb begin
      ch  = (v[4] & v[5]) ^ (~v[4] & v[6]);
      mj  = (v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]);
      t1  = v[7] + sig_up1(v[4]) + ch + k_t + w_t;
      t2  = sig_up0(v[0]) + mj;
      nxt = {t1 + t2, v[0], v[1], v[2], v[3] + t1, v[4], v[5], v[6]};
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)       v <= '0;
      else if (init) v <= h_in;
      else if (step) v <= nxt;
   end

endmodule

// File: rtl/sha256_engine.sv
module sha256_engine
   import sha256_pkg::*;
#(
   parameter int LEN_W = 64
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        load_i,
   input  logic        ivsel_i,
   input  logic [31:0] data_i,
   input  logic        last_i,
   input  logic [4:0]  nbits_i,
   output logic [31:0] q_o,
   output logic        ready_o,
   output logic        strb_o,
   output logic [2:0]  addr_o
);

   localparam int PTR_W = $clog2(BLK_WRDS);
   localparam int RND_W = $clog2(N_ROUNDS);

   generate
      if (LEN_W < 16 || LEN_W > 64) begin : g_bad_len
         $error("sha256_engine: LEN_W must lie in 16..64");
      end
   endgenerate

   eng_state_t        st;
   chain_t            hv, nxt;
   logic [PTR_W-1:0]  wptr;
   logic [RND_W-1:0]  rcnt;
   logic [2:0]        ocnt, ivcnt;
   logic [LEN_W-1:0]  len;
   logic [63:0]       len64;
   logic              pad_on, one_done, fits, done;
   logic [5:0]        vbits;
   logic [31:0]       keep_mask, one_bit, pad_word, wr_data, w_t;
   logic              acc_msg, acc_iv, wr_en, in_run;

   assign vbits     = (nbits_i == 5'd0) ? 6'd32 : {1'b0, nbits_i};
   assign keep_mask = ~(32'hffffffff >> vbits);
   assign one_bit   = (vbits == 6'd32) ? 32'h0 : (32'h80000000 >> vbits);
   assign len64     = 64'(len);
   assign acc_msg   = (st == ST_IDLE) && load_i && !ivsel_i;
   assign acc_iv    = (st == ST_IDLE) && load_i && ivsel_i && (len == '0);
   assign in_run    = (st == ST_RUN);

   always_comb begin
      if (!one_done)                                pad_word = 32'h80000000;
      else if (fits && wptr == PTR_W'(BLK_WRDS - 2)) pad_word = len64[63:32];
      else if (fits && wptr == PTR_W'(BLK_WRDS - 1)) pad_word = len64[31:0];
      else                                          pad_word = 32'h0;
   end

   assign wr_en   = acc_msg || (st == ST_PAD);
   assign wr_data = acc_msg ? (last_i ? ((data_i & keep_mask) | one_bit) : data_i)
                            : pad_word;

   sha256_sched #(.DEPTH(BLK_WRDS)) i_sched (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_idx   (wptr),
      .wr_data  (wr_data),
      .shift_en (in_run),
      .w_cur    (w_t)
   );

   sha256_round i_round (
      .clk  (clk),
      .rst  (rst),
      .init (st == ST_LOAD),
      .step (in_run),
      .h_in (hv),
      .k_t  (round_const(rcnt)),
      .w_t  (w_t),
      .nxt  (nxt)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         st <= ST_IDLE;  hv <= H_START;  wptr <= '0;  rcnt <= '0;
         ocnt <= '0;  ivcnt <= '0;  len <= '0;
         pad_on <= 1'b0;  one_done <= 1'b0;  fits <= 1'b0;  done <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (acc_iv) begin
                  hv[ivcnt] <= data_i;
                  ivcnt     <= ivcnt + 3'd1;
               end else if (acc_msg) begin
                  len  <= len + (last_i ? LEN_W'(vbits) : LEN_W'(32));
                  wptr <= wptr + 1'b1;
                  if (last_i) begin
                     pad_on   <= 1'b1;
                     one_done <= (vbits != 6'd32);
                     fits     <= (vbits != 6'd32) && (wptr <= PTR_W'(BLK_WRDS - 3));
                  end
                  if (wptr == PTR_W'(BLK_WRDS - 1)) st <= ST_LOAD;
                  else if (last_i)                  st <= ST_PAD;
               end
            end
            ST_PAD: begin
               wptr <= wptr + 1'b1;
               if (!one_done) begin
                  one_done <= 1'b1;
                  fits     <= (wptr <= PTR_W'(BLK_WRDS - 3));
               end
               if (wptr == PTR_W'(BLK_WRDS - 1)) begin
                  if (fits) done <= 1'b1;
                  st <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               rcnt <= '0;
               st   <= ST_RUN;
            end
            ST_RUN: begin
               rcnt <= rcnt + 1'b1;
               if (rcnt == RND_W'(N_ROUNDS - 1)) begin
                  for (int i = 0; i < N_CHAIN; i++) hv[i] <= hv[i] + nxt[i];
                  if (done) begin
                     ocnt <= '0;
                     st   <= ST_OUT;
                  end else if (pad_on) begin
                     fits <= one_done;
                     st   <= ST_PAD;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: begin
               ocnt <= ocnt + 3'd1;
               if (ocnt == 3'd7) begin
                  st <= ST_IDLE;  hv <= H_START;  len <= '0;  ivcnt <= '0;
                  pad_on <= 1'b0;  one_done <= 1'b0;  fits <= 1'b0;  done <= 1'b0;
               end
            end
         endcase
      end
   end

   assign ready_o = (st == ST_IDLE);
   assign strb_o  = (st == ST_OUT);
   assign addr_o  = ocnt;
   assign q_o     = hv[ocnt];

endmodule

// File: rtl/sha256_engine_chk.sv
module sha256_engine_chk (
   input logic       clk,
   input logic       rst,
   input logic       load_i,
   input logic       ivsel_i,
   input logic       last_i,
   input logic       ready_o,
   input logic       strb_o,
   input logic [2:0] addr_o
);

   // R7: the first digest word carries address 0
   assert_first_addr_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(strb_o) |-> addr_o == 3'd0);

   // R7: addresses advance by one on consecutive strobed cycles
   assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
      (strb_o && addr_o != 3'd7) |=> (strb_o && addr_o == $past(addr_o) + 3'd1));

   // R7: the strobe drops after the eighth word
   assert_eight_words_R7: assert property (@(posedge clk) disable iff (rst)
      (strb_o && addr_o == 3'd7) |=> !strb_o);

   // R3: no input is taken while the digest is being presented
   assert_ready_vs_strb_R3: assert property (@(posedge clk) disable iff (rst)
      !(ready_o && strb_o));

   // R4: a final word always leads to a busy period for padding or rounds
   assert_busy_after_last_R4: assert property (@(posedge clk) disable iff (rst)
      (load_i && ready_o && !ivsel_i && last_i) |=> !ready_o);

endmodule

bind sha256_engine sha256_engine_chk i_chk (
   .clk     (clk),
   .rst     (rst),
   .load_i  (load_i),
   .ivsel_i (ivsel_i),
   .last_i  (last_i),
   .ready_o (ready_o),
   .strb_o  (strb_o),
   .addr_o  (addr_o)
);

// File: tb/test_sha256_engine.sv
module test_sha256_engine;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        load_i = 1'b0, ivsel_i = 1'b0, last_i = 1'b0;
   logic [31:0] data_i = '0;
   logic [4:0]  nbits_i = '0;
   logic [31:0] q_o;
   logic        ready_o, strb_o;
   logic [2:0]  addr_o;

   int n_run = 0, n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   sha256_engine i_sha256_engine (
      .clk(clk), .rst(rst), .load_i(load_i), .ivsel_i(ivsel_i), .data_i(data_i),
      .last_i(last_i), .nbits_i(nbits_i), .q_o(q_o), .ready_o(ready_o),
      .strb_o(strb_o), .addr_o(addr_o));

   localparam logic [31:0] BK [64] = '{
      32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
      32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
      32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
      32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
      32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
      32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
      32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
      32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

   logic [31:0] std_iv [8] = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                               32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
   logic [31:0] mw  [64];
   logic [31:0] exp_d [8];
   logic [31:0] got_d [8];

   function automatic logic [31:0] rr(input logic [31:0] x, input int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   // Reference digest of mw[0..n-1], the last word holding v valid bits.
   task automatic ref_hash(input int n, input int v, input logic [31:0] ivw [8]);
      logic [31:0] pw [80];
      logic [31:0] w [64];
      logic [31:0] hh [8];
      logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
      int total, nblk;
      total = 32 * (n - 1) + v;
      for (int i = 0; i < 80; i++) pw[i] = (i < n) ? mw[i] : 32'h0;
      if (v < 32) pw[n-1] = pw[n-1] & ~(32'hffffffff >> v);
      pw[total / 32] = pw[total / 32] | (32'h80000000 >> (total % 32));
      nblk = (total + 65 + 511) / 512;
      pw[nblk * 16 - 1] = 32'(total);
      for (int i = 0; i < 8; i++) hh[i] = ivw[i];
      for (int bk = 0; bk < nblk; bk++) begin
         for (int t = 0; t < 64; t++)
            if (t < 16) w[t] = pw[bk * 16 + t];
            else w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
                      + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
         a = hh[0]; b = hh[1]; c = hh[2]; d = hh[3];
         e = hh[4]; f = hh[5]; g = hh[6]; h = hh[7];
         for (int t = 0; t < 64; t++) begin
            t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + BK[t] + w[t];
            t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
            h = g; g = f; f = e; e = d + t1; d = c; c = b; b = a; a = t1 + t2;
         end
         hh[0] += a; hh[1] += b; hh[2] += c; hh[3] += d;
         hh[4] += e; hh[5] += f; hh[6] += g; hh[7] += h;
      end
      for (int i = 0; i < 8; i++) exp_d[i] = hh[i];
   endtask

   task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // Present one word at a negedge once ready is seen, then release.
   task automatic send(input logic [31:0] d, input logic iv, input logic lst, input logic [4:0] nb);
      while (!ready_o) @(negedge clk);
      load_i = 1'b1; ivsel_i = iv; data_i = d; last_i = lst; nbits_i = nb;
      @(negedge clk);
      load_i = 1'b0; ivsel_i = 1'b0; last_i = 1'b0; nbits_i = '0; data_i = '0;
   endtask

   task automatic collect(input string req);
      while (!strb_o) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         check(strb_o && addr_o == 3'(i), "R7", {29'h0, addr_o}, 32'(i));
         got_d[i] = q_o;
         @(negedge clk);
      end
      check(!strb_o, "R7", {31'h0, strb_o}, 32'h0);
      for (int i = 0; i < 8; i++) check(got_d[i] == exp_d[i], req, got_d[i], exp_d[i]);
   endtask

   task automatic t_reset;
      check(ready_o == 1'b1, "R1", {31'h0, ready_o}, 32'h1);
      check(strb_o == 1'b0, "R1", {31'h0, strb_o}, 32'h0);
   endtask

   task automatic t_abc;   // R2: three-byte message, known digest
      send(32'h61626300, 1'b0, 1'b1, 5'd24);
      exp_d = '{32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
                32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};
      collect("R2");
   endtask

   task automatic t_spill;   // R5: 14 full words push the count into a second block
      string s = "abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq";
      for (int i = 0; i < 14; i++)
         send({s[4*i], s[4*i+1], s[4*i+2], s[4*i+3]}, 1'b0, (i == 13), 5'd0);
      exp_d = '{32'h248d6a61, 32'hd20638b8, 32'he5c02693, 32'h0c3e6039,
                32'ha33ce459, 32'h64ff2167, 32'hf6ecedd4, 32'h19db06c1};
      collect("R5");
   endtask

   task automatic t_masking;   // R4: low garbage bits ignored, 1-bit and 32-bit tails
      send(32'h616263ff, 1'b0, 1'b1, 5'd24);
      exp_d = '{32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
                32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};
      collect("R4");
      mw[0] = 32'hdeadbeef; mw[1] = 32'hffffffff;
      send(mw[0], 1'b0, 1'b0, 5'd0);
      send(mw[1], 1'b0, 1'b1, 5'd1);
      ref_hash(2, 1, std_iv);
      collect("R4");
      for (int i = 0; i < 15; i++) mw[i] = 32'h01234567 * (i + 3);
      for (int i = 0; i < 15; i++) send(mw[i], 1'b0, (i == 14), 5'd17);
      ref_hash(15, 17, std_iv);
      collect("R5");
   endtask

   task automatic t_multi_busy;   // R6 and R3: full block, busy window with loads held high
      int busy;
      for (int i = 0; i < 17; i++) mw[i] = 32'h9e3779b9 ^ (32'(i) << 5) ^ 32'(i * 7);
      for (int i = 0; i < 16; i++) send(mw[i], 1'b0, 1'b0, 5'd0);
      busy = 0;
      load_i = 1'b1; data_i = 32'hbadc0de5; ivsel_i = 1'b0;
      while (!ready_o) begin
         busy++;
         ivsel_i = (busy % 3 == 0);
         @(negedge clk);
      end
      load_i = 1'b0; ivsel_i = 1'b0; data_i = '0;
      check(busy == 65, "R6", 32'(busy), 32'd65);
      send(mw[16], 1'b0, 1'b1, 5'd8);
      ref_hash(17, 8, std_iv);
      collect("R3");
   endtask

   task automatic t_custom_iv;   // R8 then R10
      logic [31:0] civ [8];
      for (int i = 0; i < 8; i++) civ[i] = 32'hc0de0000 + 32'(i * 32'h1111);
      for (int i = 0; i < 8; i++) send(civ[i], 1'b1, 1'b0, 5'd0);
      mw[0] = 32'h48656c6c; mw[1] = 32'h6f000000;
      send(mw[0], 1'b0, 1'b0, 5'd0);
      send(mw[1], 1'b0, 1'b1, 5'd8);
      ref_hash(2, 8, civ);
      collect("R8");
      send(32'h61626300, 1'b0, 1'b1, 5'd24);
      exp_d = '{32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
                32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};
      collect("R10");
   endtask

   task automatic t_iv_midmsg;   // R9: IV word after a message word is ignored
      mw[0] = 32'h11223344; mw[1] = 32'h55667788;
      send(mw[0], 1'b0, 1'b0, 5'd0);
      send(32'hffffffff, 1'b1, 1'b0, 5'd0);
      send(mw[1], 1'b0, 1'b1, 5'd0);
      ref_hash(2, 32, std_iv);
      collect("R9");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_abc();
      t_spill();
      t_masking();
      t_multi_busy();
      t_custom_iv();
      t_iv_midmsg();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule